// File: doc/BRIEF.md
# Posted Interrupt Controller with Software Posting

The block gathers 24 hardware interrupt sources into latched "posted" bits, arranged as three byte-wide posted-status registers. A single-cycle pulse on a source input sets its posted bit, and the bit stays set until software clears it. Four byte-wide enable registers sit beside them. The first three gate each posted bit into a "pending" vector. A priority encoder turns that vector into an interrupt request and the index of the winning source. The fourth enable register carries the global software-posting mode bit in its bit 7.

Software reaches all seven registers over a simple byte-wide bus: an address, a write strobe, write data, and read data that follows the address combinationally. A write to a posted-status register is read in one of two ways, depending on the mode bit. With the mode bit at 0, a written 0 clears the bit and a written 1 leaves it alone. With the mode bit at 1, a written 1 posts the bit and a written 0 leaves it alone. This makes it possible to raise any interrupt from software when testing handlers. Posting, whether by hardware or by software, never depends on the enable bits.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset, every posted bit and every enable bit is 0, so all seven registers read 0x00, `irq` is 0 and `irq_idx` is 0. Bus writes are ignored until the internal reset is released, two clock edges after `rst_n` rises.
- R2: A one-cycle pulse on `hw_evt[s]` sets posted bit s at the next clock edge. Source s lives in posted-status register s/8 (addresses 0xDA, 0xDB, 0xDC for registers 0, 1, 2) at bit s%8, and reading that register returns its posted bits.
- R3: Enable register k (k = 0..2, at address 0xE0+k) bit i lets posted source 8k+i become pending. A posted bit whose enable bit is 0 still reads back as 1 but does not raise `irq`.
- R4: With the mode bit (bit 7 of the enable register at 0xE3) at 0, a write to a posted-status register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R5: With the mode bit at 1, a write to a posted-status register sets each bit written as 1 and leaves each bit written as 0 unchanged, whatever the enable bits are.
- R6: When a hardware pulse and a clearing write hit the same posted bit in the same cycle, the bit ends up set.
- R7: `irq` is 1 exactly when some pending bit is 1, and `irq_idx` then gives the lowest pending source number (register 0 bit 0 is 0, register 2 bit 7 is 23). When nothing is pending, `irq_idx` is 0.
- R8: Bits 7 and 6 of posted-status register 2 (sources 23 and 22) are reserved. They always read 0 and are set neither by hardware pulses nor by software posting.
- R9: The four enable registers at 0xE0..0xE3 hold and read back all eight written bits, independently of one another. Bits 6..0 of 0xE3 are plain storage.
- R10: Addresses outside 0xDA..0xDC and 0xE0..0xE3 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hw_evt | input | 24 | Per-source single-cycle event pulses |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Some enabled posted source is pending |
| irq_idx | output | 5 | Lowest-numbered pending source |

## Verification
The bench builds the block with its default parameters: three posted-status registers of eight bits, four enable registers, and the two top bits of the last status register reserved. The status and enable registers therefore sit at 0xDA..0xDC and 0xE0..0xE3. With 24 sources, the priority search crosses two byte boundaries, and the reserved bits sit next to live ones, so both can be tested. A long phase of random writes also reaches the mode bit, which flips the meaning of later writes in the middle of traffic.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // Which register group a bus address falls in
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_ENAB = 2'd2
  } pirq_tgt_e;

  localparam int unsigned OFF_W = 3;

  typedef struct packed {
    pirq_tgt_e        tgt;
    logic [OFF_W-1:0] off;
  } pirq_dec_t;
endpackage

// File: rtl/pirq_rst_sync.sv
module pirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pirq_bank.sv
module pirq_bank #(
  parameter int unsigned            W     = 8,
  parameter logic [W-1:0]           VALID = '1
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic [W-1:0] evt,
  input  logic         wr_sel,
  input  logic         sw_post_mode,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] posted
);
  logic [W-1:0] posted_q, posted_d;
  logic         upd_en;

  // Next state: a write is applied first, then hardware events win
  always_comb begin
    posted_d = posted_q;
    if (wr_sel) begin
      if (sw_post_mode) posted_d = posted_q | wdata;
      else              posted_d = posted_q & wdata;
    end
    posted_d = (posted_d | evt) & VALID;
  end

  assign upd_en = wr_sel | (|evt);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    posted_q <= '0;
    else if (upd_en) posted_q <= posted_d;
  end

  assign posted = posted_q;

  // R6: hardware events always land
  assert_hw_set_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|(evt & VALID)) |=> ((posted_q & $past(evt & VALID)) == $past(evt & VALID)));

  // R4: clear mode removes bits written 0 that saw no event
  assert_clear_mode_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_sel && !sw_post_mode) |=> ((posted_q & ~$past(wdata) & ~$past(evt)) == '0));

  // R5: post mode sets bits written 1
  assert_post_mode_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_sel && sw_post_mode) |=> ((posted_q & $past(wdata) & VALID) == ($past(wdata) & VALID)));

  // R8: reserved bits stay empty
  assert_reserved_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((posted_q & ~VALID) == '0));
endmodule

// File: rtl/pirq_prio.sv
module pirq_prio #(
  parameter int unsigned N     = 24,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  output logic             irq,
  output logic [IDX_W-1:0] idx
);
  // Lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    irq = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        irq = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
  parameter int unsigned                    DATA_W    = 8,
  parameter int unsigned                    ADDR_W    = 8,
  parameter int unsigned                    NUM_STAT  = 3,
  parameter int unsigned                    NUM_ENAB  = 4,
  parameter logic [ADDR_W-1:0]              STAT_BASE = 8'hDA,
  parameter logic [ADDR_W-1:0]              ENAB_BASE = 8'hE0,
  parameter int unsigned                    MODE_REG  = 3,
  parameter int unsigned                    MODE_BIT  = 7,
  parameter logic [NUM_STAT*DATA_W-1:0]     SRC_VALID = 24'h3F_FFFF,
  localparam int unsigned                   NUM_SRC   = NUM_STAT * DATA_W,
  localparam int unsigned                   IDX_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_evt,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq,
  output logic [IDX_W-1:0]   irq_idx
);
  import pirq_pkg::*;

  localparam int unsigned ESEL_W = (NUM_ENAB > 1) ? $clog2(NUM_ENAB) : 1;

  logic rst_q_n;

  pirq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Address decode
  pirq_dec_t          dec;
  logic [ADDR_W-1:0]  stat_off, enab_off;

  always_comb begin
    stat_off = bus_addr - STAT_BASE;
    enab_off = bus_addr - ENAB_BASE;
    dec.tgt  = TGT_NONE;
    dec.off  = '0;
    if (stat_off < ADDR_W'(NUM_STAT)) begin
      dec.tgt = TGT_STAT;
      dec.off = OFF_W'(stat_off);
    end else if (enab_off < ADDR_W'(NUM_ENAB)) begin
      dec.tgt = TGT_ENAB;
      dec.off = OFF_W'(enab_off);
    end
  end

  // Enable registers
  logic [DATA_W-1:0]          enab_q [NUM_ENAB];
  logic [DATA_W-1:0]          enab_d [NUM_ENAB];
  logic [NUM_ENAB-1:0]        enab_we;
  logic [NUM_ENAB*DATA_W-1:0] enab_flat;
  logic                       sw_post_mode;

  generate
    for (genvar e = 0; e < NUM_ENAB; e++) begin : g_enab
      always_comb begin
        enab_we[e] = bus_wr && (dec.tgt == TGT_ENAB) && (dec.off == OFF_W'(e));
        enab_d[e]  = enab_we[e] ? bus_wdata : enab_q[e];
      end

      always_ff @(posedge clk or negedge rst_q_n) begin
        if (!rst_q_n)        enab_q[e] <= '0;
        else if (enab_we[e]) enab_q[e] <= enab_d[e];
      end

      assign enab_flat[e*DATA_W +: DATA_W] = enab_q[e];
    end
  endgenerate

  assign sw_post_mode = enab_q[MODE_REG][MODE_BIT];

  // Posted-status banks
  logic [DATA_W-1:0]  posted [NUM_STAT];
  logic [NUM_SRC-1:0] pend;

  generate
    for (genvar k = 0; k < NUM_STAT; k++) begin : g_bank
      logic stat_we;
      assign stat_we = bus_wr && (dec.tgt == TGT_STAT) && (dec.off == OFF_W'(k));

      pirq_bank #(
        .W     (DATA_W),
        .VALID (SRC_VALID[k*DATA_W +: DATA_W])
      ) u_bank (
        .clk          (clk),
        .rst_q_n      (rst_q_n),
        .evt          (hw_evt[k*DATA_W +: DATA_W]),
        .wr_sel       (stat_we),
        .sw_post_mode (sw_post_mode),
        .wdata        (bus_wdata),
        .posted       (posted[k])
      );

      assign pend[k*DATA_W +: DATA_W] = posted[k] & enab_q[k];
    end
  endgenerate

  // Read mux
  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_STAT; k++)
      if (dec.tgt == TGT_STAT && dec.off == OFF_W'(k)) bus_rdata = posted[k];
    for (int e = 0; e < NUM_ENAB; e++)
      if (dec.tgt == TGT_ENAB && dec.off == OFF_W'(e)) bus_rdata = enab_q[e];
  end

  pirq_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .pend (pend),
    .irq  (irq),
    .idx  (irq_idx)
  );

  // R7: winner is pending and nothing below it is
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq |-> (pend[irq_idx] && ((pend & ((NUM_SRC'(1) << irq_idx) - NUM_SRC'(1))) == '0)));

  // R7: idle request carries index 0 and nothing pending
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !irq |-> (pend == '0 && irq_idx == '0));

  // R10: writes outside the enable window leave the enable registers alone
  assert_enab_hold_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_wr && dec.tgt != TGT_ENAB) |=> $stable(enab_flat));
endmodule

// File: tb/pirq_ctrl_tb.sv
module pirq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] VALID = 24'h3F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] hw_evt;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq;
  logic [4:0]  irq_idx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pirq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_evt    (hw_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .irq_idx   (irq_idx)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done     = 1'b0;
  string cur_req  = "R1";

  // Behavioural reference state
  bit [23:0] m_post;
  bit [7:0]  m_enab [4];

  function automatic bit [7:0] exp_rdata(input bit [7:0] a);
    if (a >= 8'hDA && a <= 8'hDC) return m_post[(a - 8'hDA) * 8 +: 8];
    if (a >= 8'hE0 && a <= 8'hE3) return m_enab[a - 8'hE0];
    return 8'h00;
  endfunction

  task automatic check(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit [23:0] pend;
    int        win;
    pend = m_post & {m_enab[2], m_enab[1], m_enab[0]};
    win  = -1;
    for (int i = 23; i >= 0; i--) if (pend[i]) win = i;
    check(int'(bus_rdata), int'(exp_rdata(bus_addr)), "rdata");
    check(int'(irq), (win >= 0) ? 1 : 0, "irq");
    check(int'(irq_idx), (win >= 0) ? win : 0, "irq_idx");
  endtask

  task automatic model_step(input bit in_rst);
    bit        mode;
    int        k;
    bit [23:0] wmask, wbits;
    if (in_rst) return;
    mode = m_enab[3][7];
    if (bus_wr && bus_addr >= 8'hDA && bus_addr <= 8'hDC) begin
      k     = bus_addr - 8'hDA;
      wmask = 24'hFF << (k * 8);
      wbits = 24'(bus_wdata) << (k * 8);
      if (mode) m_post = m_post | wbits;
      else      m_post = m_post & (~wmask | wbits);
    end
    if (bus_wr && bus_addr >= 8'hE0 && bus_addr <= 8'hE3)
      m_enab[bus_addr - 8'hE0] = bus_wdata;
    m_post = (m_post | hw_evt) & VALID;
  endtask

  int rst_wait = 0;

  // One cycle: compare at mid-low phase, commit at posedge, return after negedge
  task automatic cyc();
    #1;
    compare_all();
    @(posedge clk);
    model_step(rst_wait > 0);
    if (rst_wait > 0) rst_wait--;
    @(negedge clk);
    hw_evt = '0;
    bus_wr = 1'b0;
  endtask

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
  endtask

  task automatic rd(input bit [7:0] a);
    bus_addr = a;
    cyc();
  endtask

  task automatic pulse(input bit [23:0] ev);
    hw_evt = ev;
    cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_post = '0;
    for (int e = 0; e < 4; e++) m_enab[e] = '0;
    rst_n = 1'b0; hw_evt = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n    = 1'b1;
    rst_wait = 2;

    // R1: reset state, writes during the sync window are dropped
    cur_req = "R1";
    wr(8'hE0, 8'hFF);
    wr(8'hE3, 8'h80);
    for (int a = 8'hD8; a <= 8'hE5; a++) rd(8'(a));

    // R2: hardware pulses post their bits
    cur_req = "R2";
    pulse(24'h02_0208);
    rd(8'hDA); rd(8'hDB); rd(8'hDC);
    pulse(24'h80_0001);
    rd(8'hDA); rd(8'hDB);

    // R3: enables gate pending, posting unaffected
    cur_req = "R3";
    rd(8'hDA);
    wr(8'hE1, 8'h02);
    rd(8'hDB);
    wr(8'hE0, 8'h08);
    wr(8'hE1, 8'h00);
    rd(8'hDA);

    // R4: clear mode
    cur_req = "R4";
    wr(8'hDA, 8'hF7);
    rd(8'hDA);
    wr(8'hDB, 8'hFF);
    rd(8'hDB);
    wr(8'hE0, 8'hFF); wr(8'hE1, 8'hFF); wr(8'hE2, 8'hFF);
    wr(8'hDA, 8'h00);
    rd(8'hDB);

    // R6: event and clearing write on the same bit
    cur_req = "R6";
    bus_addr = 8'hDB; bus_wdata = 8'h00; bus_wr = 1'b1; hw_evt = 24'h00_0200;
    cyc();
    rd(8'hDB);

    // R5: post mode ignores zeros and enables
    cur_req = "R5";
    wr(8'hE2, 8'h00);
    wr(8'hE3, 8'h80);
    wr(8'hDC, 8'h15);
    rd(8'hDC);
    wr(8'hDC, 8'h00);
    rd(8'hDC);
    wr(8'hDA, 8'h40);
    rd(8'hDA);

    // R8: reserved bits
    cur_req = "R8";
    wr(8'hDC, 8'hFF);
    rd(8'hDC);
    pulse(24'hFF_FFFF);
    rd(8'hDC);

    // R7: priority walk across all sources
    cur_req = "R7";
    wr(8'hE3, 8'h00);
    wr(8'hE0, 8'hFF); wr(8'hE1, 8'hFF); wr(8'hE2, 8'hFF);
    wr(8'hDA, 8'h00); wr(8'hDB, 8'h00); wr(8'hDC, 8'h00);
    rd(8'hDA);
    pulse(24'h20_0000);
    for (int s = 20; s >= 0; s--) pulse(24'(1) << s);
    for (int k = 0; k < 3; k++) wr(8'(8'hDA + k), 8'h00);

    // R9: enable registers hold their values independently
    cur_req = "R9";
    wr(8'hE0, 8'hA5); wr(8'hE1, 8'h3C); wr(8'hE2, 8'h81); wr(8'hE3, 8'h7E);
    for (int e = 0; e < 4; e++) rd(8'(8'hE0 + e));

    // R10: unmapped addresses
    cur_req = "R10";
    pulse(24'h00_0101);
    wr(8'hD9, 8'h00); wr(8'hDD, 8'hFF); wr(8'hDF, 8'hFF); wr(8'hE4, 8'h00);
    rd(8'hD9); rd(8'hDD); rd(8'hE4);
    for (int a = 8'hDA; a <= 8'hE3; a++) rd(8'(a));

    // R7: random traffic across modes
    cur_req = "R7";
    for (int n = 0; n < 3000; n++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: bus_addr = 8'hDA; 1: bus_addr = 8'hDB; 2: bus_addr = 8'hDC;
        3: bus_addr = 8'hDD; 4: bus_addr = 8'hD9; 5: bus_addr = 8'hE0;
        6: bus_addr = 8'hE1; 7: bus_addr = 8'hE2; 8: bus_addr = 8'hE3;
        default: bus_addr = 8'hE4;
      endcase
      bus_wdata = 8'($urandom);
      bus_wr    = ($urandom_range(0, 2) == 0);
      hw_evt    = 24'($urandom & $urandom & $urandom);
      cyc();
    end

    finish_run();
  end
endmodule